// File: doc/BRIEF.md
# CRC-16 coprocessor

This block computes a 16-bit cyclic redundancy checksum over a stream of bytes, one byte per clock, using the polynomial x^16 + x^12 + x^5 + 1. A caller first pulses `start_i` with a two-bit preset selector and a bit-order selector. The engine then loads one of four initial values and folds in each byte presented with `data_valid_i`. A later pulse on `done_i` freezes the running value into a result register, which is read out as separate upper and lower bytes. The same pulse raises a completion status, a zero-residue status and a one-cycle completion request.

Bytes are processed least significant bit first by default, which uses the reflected polynomial 8408h. When the order selector is high at start, bytes are processed most significant bit first with the unreflected polynomial 1021h. No final inversion is applied. A frame followed by its own checksum therefore leaves a zero residue, and the zero-residue flag reports a good frame. In least-significant-first mode the checksum is appended low byte first. In most-significant-first mode it is appended high byte first.

Top module: `crc16_coproc`

## Requirements
- R1: On `start_i`, the running value is loaded from `preset_sel_i`: 2'b00 gives 16'h0000, 2'b01 gives 16'h6363, 2'b10 gives 16'hA671 and 2'b11 gives 16'hFFFF. A `done_i` with no bytes after the start reports that preset.
- R2: `start_i` clears `ready_o` and `ok_o` on the next edge. It takes priority over `data_valid_i` and `done_i` in the same cycle, and it raises no `irq_o`.
- R3: With `msb_first_i` low at start, each byte is folded in least significant bit first using the reflected polynomial 16'h8408. From preset 2'b01, the bytes 8'h00, 8'h00 give 16'h1EA0.
- R4: With `msb_first_i` high at start, each byte is folded in most significant bit first using the polynomial 16'h1021. The order is sampled only at `start_i`; later changes of `msb_first_i` have no effect until the next start.
- R5: Every cycle with `data_valid_i` high and `start_i` low updates the running value by exactly one byte.
- R6: `done_i` without `start_i` copies the running value, including any byte valid in the same cycle, into the result on the next edge. `crc_hi_o` carries result bits 15:8 and `crc_lo_o` carries bits 7:0.
- R7: After such a `done_i`, `ready_o` is 1 from the next edge until the next `start_i`.
- R8: After such a `done_i`, `ok_o` is 1 exactly when the latched result is 16'h0000, and is held until the next `start_i` or `done_i`.
- R9: `irq_o` is high for the single cycle following each accepted `done_i` and low at all other times.
- R10: The result outputs change only on an accepted `done_i`. Bytes and starts without done leave them unchanged.
- R11: A frame followed by its own checksum sets `ok_o` at done. The checksum is appended low byte first in least-significant-first mode and high byte first in most-significant-first mode.
- R12: While `rst` is high, all outputs are 0 and the running value is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load preset, latch bit order, clear status |
| preset_sel_i | input | 2 | Preset selector sampled on start |
| msb_first_i | input | 1 | Bit order selector sampled on start |
| data_valid_i | input | 1 | Byte on data_i is folded in this cycle |
| data_i | input | 8 | Input byte |
| done_i | input | 1 | Latch result and set status |
| crc_hi_o | output | 8 | Result bits 15:8 |
| crc_lo_o | output | 8 | Result bits 7:0 |
| ready_o | output | 1 | Calculation finished |
| ok_o | output | 1 | Latched result is zero |
| irq_o | output | 1 | One-cycle completion request |

## Verification
The bound properties check the status sequencing on every cycle. They cover the clearing of the flags by a start, the setting and holding of ready, the single-cycle request after each done, the agreement between ok and a zero result, and the freezing of the result between done pulses. The checksum arithmetic can only be shown by the bench's scenarios. So can the preset mapping, the bit-order choice and its sampling at start, same-cycle byte and done handling, and the zero residue of a frame carrying its own checksum. The bench compares all of these against a bit-serial reference model on every clock.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int DATA_W = 8;
  localparam int HALF_W = CRC_W / 2;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam crc_t POLY_FWD = 16'h1021;
  localparam crc_t POLY_REV = 16'h8408;

  localparam crc_t PRESET_0 = 16'h0000;
  localparam crc_t PRESET_1 = 16'h6363;
  localparam crc_t PRESET_2 = 16'hA671;
  localparam crc_t PRESET_3 = 16'hFFFF;
endpackage

// File: rtl/crc16_preset_sel.sv
module crc16_preset_sel
  import crc16_pkg::*;
#(
  parameter crc_t P0 = PRESET_0,
  parameter crc_t P1 = PRESET_1,
  parameter crc_t P2 = PRESET_2,
  parameter crc_t P3 = PRESET_3
) (
  input  logic [1:0] sel_i,
  output crc_t       value_o
);
  always_comb begin
    unique case (sel_i)
      2'b00:   value_o = P0;
      2'b01:   value_o = P1;
      2'b10:   value_o = P2;
      default: value_o = P3;
    endcase
  end
endmodule

// File: rtl/crc16_byte_step.sv
module crc16_byte_step
  import crc16_pkg::*;
#(
  parameter int   W        = CRC_W,
  parameter int   DW       = DATA_W,
  parameter logic [W-1:0] POLY_N = POLY_FWD,
  parameter logic [W-1:0] POLY_R = POLY_REV
) (
  input  logic [W-1:0]  cur_i,
  input  logic [DW-1:0] data_i,
  input  logic          msb_first_i,
  output logic [W-1:0]  next_o
);
  localparam int PAD = W - DW;

  logic [W-1:0] rev_chain [0:DW];
  logic [W-1:0] fwd_chain [0:DW];

  // reflected shift register: byte enters at the low end
  assign rev_chain[0] = cur_i ^ {{PAD{1'b0}}, data_i};
  // forward shift register: byte enters at the high end
  assign fwd_chain[0] = cur_i ^ {data_i, {PAD{1'b0}}};

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign rev_chain[i+1] = rev_chain[i][0]
                          ? ((rev_chain[i] >> 1) ^ POLY_R)
                          : (rev_chain[i] >> 1);
    assign fwd_chain[i+1] = fwd_chain[i][W-1]
                          ? ((fwd_chain[i] << 1) ^ POLY_N)
                          : (fwd_chain[i] << 1);
  end

  assign next_o = msb_first_i ? fwd_chain[DW] : rev_chain[DW];
endmodule

// File: rtl/crc16_status.sv
module crc16_status (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic latch_i,
  input  logic zero_i,
  output logic ready_o,
  output logic ok_o,
  output logic irq_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ready_o <= 1'b0;
      ok_o    <= 1'b0;
      irq_o   <= 1'b0;
    end else if (clear_i) begin
      ready_o <= 1'b0;
      ok_o    <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= latch_i;
      if (latch_i) begin
        ready_o <= 1'b1;
        ok_o    <= zero_i;
      end
    end
  end
endmodule

// File: rtl/crc16_coproc.sv
module crc16_coproc
  import crc16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        preset_sel_i,
  input  logic              msb_first_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_i,
  output logic [HALF_W-1:0] crc_hi_o,
  output logic [HALF_W-1:0] crc_lo_o,
  output logic              ready_o,
  output logic              ok_o,
  output logic              irq_o
);
  crc_t crc_q, res_q, preset_w, step_w, crc_next;
  logic msb_q;
  logic accept_done;

  crc16_preset_sel u_preset (
    .sel_i   (preset_sel_i),
    .value_o (preset_w)
  );

  crc16_byte_step u_step (
    .cur_i       (crc_q),
    .data_i      (data_i),
    .msb_first_i (msb_q),
    .next_o      (step_w)
  );

  assign crc_next    = data_valid_i ? step_w : crc_q;
  assign accept_done = done_i && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
      msb_q <= 1'b0;
      res_q <= '0;
    end else if (start_i) begin
      crc_q <= preset_w;
      msb_q <= msb_first_i;
    end else begin
      crc_q <= crc_next;
      if (done_i) res_q <= crc_next;
    end
  end

  crc16_status u_status (
    .clk     (clk),
    .rst     (rst),
    .clear_i (start_i),
    .latch_i (accept_done),
    .zero_i  (crc_next == '0),
    .ready_o (ready_o),
    .ok_o    (ok_o),
    .irq_o   (irq_o)
  );

  assign crc_hi_o = res_q[CRC_W-1:HALF_W];
  assign crc_lo_o = res_q[HALF_W-1:0];
endmodule

// File: rtl/crc16_checker.sv
module crc16_checker
  import crc16_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              done_i,
  input logic [HALF_W-1:0] crc_hi_o,
  input logic [HALF_W-1:0] crc_lo_o,
  input logic              ready_o,
  input logic              ok_o,
  input logic              irq_o
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!ready_o && !ok_o && !irq_o));

  a_r7_done_sets_ready: assert property (@(posedge clk) disable iff (rst)
    (done_i && !start_i) |=> ready_o);

  a_r7_ready_holds: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_i) |=> ready_o);

  a_r8_ok_needs_ready: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> ready_o);

  a_r8_ok_zero_result: assert property (@(posedge clk) disable iff (rst)
    ok_o |-> ({crc_hi_o, crc_lo_o} == '0));

  a_r9_irq_after_done: assert property (@(posedge clk) disable iff (rst)
    (done_i && !start_i) |=> irq_o);

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (!done_i || start_i) |=> !irq_o);

  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    (!done_i || start_i) |=> $stable({crc_hi_o, crc_lo_o}));
endmodule

bind crc16_coproc crc16_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .done_i   (done_i),
  .crc_hi_o (crc_hi_o),
  .crc_lo_o (crc_lo_o),
  .ready_o  (ready_o),
  .ok_o     (ok_o),
  .irq_o    (irq_o)
);

// File: tb/tb_crc16_coproc.sv
module tb_crc16_coproc;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] preset_sel_i = 2'b00;
  logic       msb_first_i = 1'b0;
  logic       data_valid_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       done_i = 1'b0;
  logic [7:0] crc_hi_o, crc_lo_o;
  logic       ready_o, ok_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_coproc dut (
    .clk(clk), .rst(rst), .start_i(start_i), .preset_sel_i(preset_sel_i),
    .msb_first_i(msb_first_i), .data_valid_i(data_valid_i), .data_i(data_i),
    .done_i(done_i), .crc_hi_o(crc_hi_o), .crc_lo_o(crc_lo_o),
    .ready_o(ready_o), .ok_o(ok_o), .irq_o(irq_o)
  );

  // ---------------- reference model ----------------
  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int k = 0; k < 16; k++) r[k] = v[15-k];
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = v[7-k];
    return r;
  endfunction

  // bit-serial, one message bit at a time, most significant first
  function automatic logic [15:0] serial_fwd(input logic [15:0] c, input logic [7:0] d);
    logic fb;
    for (int k = 7; k >= 0; k--) begin
      fb = c[15] ^ d[k];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] d, input bit msb);
    if (msb) return serial_fwd(c, d);
    return rev16(serial_fwd(rev16(c), rev8(d)));
  endfunction

  function automatic logic [15:0] ref_preset(input logic [1:0] s);
    logic [15:0] t [4] = '{16'h0000, 16'h6363, 16'hA671, 16'hFFFF};
    return t[s];
  endfunction

  logic [15:0] m_crc, m_res, nx;
  logic        m_msb, m_ready, m_ok, m_irq;

  always @(posedge clk) begin
    if (rst) begin
      m_crc = 0; m_res = 0; m_msb = 0; m_ready = 0; m_ok = 0; m_irq = 0;
    end else if (start_i) begin
      m_crc = ref_preset(preset_sel_i); m_msb = msb_first_i;
      m_ready = 0; m_ok = 0; m_irq = 0;
    end else begin
      nx = data_valid_i ? ref_byte(m_crc, data_i, m_msb) : m_crc;
      m_crc = nx;
      m_irq = done_i;
      if (done_i) begin m_res = nx; m_ready = 1; m_ok = (nx == 0); end
    end
  end

  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R6 R7 R8 R9 R12 via model)
  always @(negedge clk) begin
    if (!finished) begin
      check({crc_hi_o, crc_lo_o} == m_res, "R6 model result", {crc_hi_o, crc_lo_o}, m_res);
      check({ready_o, ok_o, irq_o} == {m_ready, m_ok, m_irq}, "R7 model flags",
            {ready_o, ok_o, irq_o}, {m_ready, m_ok, m_irq});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    start_i = 0; data_valid_i = 0; done_i = 0;
    @(negedge clk);
  endtask

  task automatic do_start(input logic [1:0] sel, input bit msb);
    start_i = 1; preset_sel_i = sel; msb_first_i = msb; data_valid_i = 0; done_i = 0;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic feed(input logic [7:0] b);
    data_valid_i = 1; data_i = b; done_i = 0;
    @(negedge clk);
    data_valid_i = 0;
  endtask

  task automatic finish_calc();
    done_i = 1;
    @(negedge clk);
    done_i = 0;
  endtask

  logic [15:0] got;

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check({crc_hi_o, crc_lo_o, ready_o, ok_o, irq_o} == 0, "R12 reset outputs",
          {crc_hi_o, crc_lo_o, ready_o, ok_o, irq_o}, 0);
    rst = 0;
    idle();

    // R1 presets
    for (int s = 0; s < 4; s++) begin
      do_start(s[1:0], 0);
      finish_calc();
      check({crc_hi_o, crc_lo_o} == ref_preset(s[1:0]), "R1 preset", {crc_hi_o, crc_lo_o}, ref_preset(s[1:0]));
      check(irq_o == 1, "R9 irq after done", irq_o, 1);
      check(ok_o == (s == 0), "R8 ok for preset", ok_o, (s == 0));
      idle();
      check(irq_o == 0, "R9 irq single cycle", irq_o, 0);
      check(ready_o == 1, "R7 ready held", ready_o, 1);
    end

    // R3 known value
    do_start(2'b01, 0);
    check(ready_o == 0, "R2 start clears ready", ready_o, 0);
    feed(8'h00); feed(8'h00);
    finish_calc();
    check({crc_hi_o, crc_lo_o} == 16'h1EA0, "R3 known value", {crc_hi_o, crc_lo_o}, 16'h1EA0);

    // R11 residue, LSB-first, preset 01
    do_start(2'b01, 0);
    feed(8'h12); feed(8'h34); feed(8'h56);
    finish_calc();
    got = {crc_hi_o, crc_lo_o};
    do_start(2'b01, 0);
    feed(8'h12); feed(8'h34); feed(8'h56); feed(got[7:0]); feed(got[15:8]);
    finish_calc();
    check(ok_o == 1, "R11 residue lsb", ok_o, 1);

    // R4 + R11 residue, MSB-first, preset 11
    do_start(2'b11, 1);
    feed(8'hA5); feed(8'h3C);
    finish_calc();
    got = {crc_hi_o, crc_lo_o};
    check(got == ref_byte(ref_byte(16'hFFFF, 8'hA5, 1), 8'h3C, 1), "R4 msb value", got,
          ref_byte(ref_byte(16'hFFFF, 8'hA5, 1), 8'h3C, 1));
    do_start(2'b11, 1);
    feed(8'hA5); feed(8'h3C); feed(got[15:8]); feed(got[7:0]);
    finish_calc();
    check(ok_o == 1, "R11 residue msb", ok_o, 1);

    // R4 order sampled only at start
    do_start(2'b10, 0);
    msb_first_i = 1;
    feed(8'h5A); feed(8'hC3);
    finish_calc();
    check({crc_hi_o, crc_lo_o} == ref_byte(ref_byte(16'hA671, 8'h5A, 0), 8'hC3, 0),
          "R4 order latched", {crc_hi_o, crc_lo_o}, ref_byte(ref_byte(16'hA671, 8'h5A, 0), 8'hC3, 0));

    // R6 byte valid in the done cycle is included; R5 back-to-back bytes
    do_start(2'b00, 0);
    feed(8'h01);
    data_valid_i = 1; data_i = 8'h02; done_i = 1;
    @(negedge clk);
    data_valid_i = 0; done_i = 0;
    check({crc_hi_o, crc_lo_o} == ref_byte(ref_byte(16'h0000, 8'h01, 0), 8'h02, 0),
          "R6 same-cycle byte", {crc_hi_o, crc_lo_o}, ref_byte(ref_byte(16'h0000, 8'h01, 0), 8'h02, 0));

    // R10 bytes without done leave result unchanged
    got = {crc_hi_o, crc_lo_o};
    feed(8'hFF); feed(8'h77);
    check({crc_hi_o, crc_lo_o} == got, "R10 result held", {crc_hi_o, crc_lo_o}, got);

    // R2 start wins over done and byte in same cycle
    start_i = 1; preset_sel_i = 2'b01; msb_first_i = 0; done_i = 1; data_valid_i = 1; data_i = 8'h99;
    @(negedge clk);
    start_i = 0; done_i = 0; data_valid_i = 0;
    check({ready_o, irq_o} == 2'b00, "R2 start priority flags", {ready_o, irq_o}, 0);
    check({crc_hi_o, crc_lo_o} == got, "R2 start keeps result", {crc_hi_o, crc_lo_o}, got);
    finish_calc();
    check({crc_hi_o, crc_lo_o} == 16'h6363, "R2 start ignored byte", {crc_hi_o, crc_lo_o}, 16'h6363);

    // R12 reset mid-run
    rst = 1;
    idle();
    check({crc_hi_o, crc_lo_o, ready_o, ok_o, irq_o} == 0, "R12 reset again",
          {crc_hi_o, crc_lo_o, ready_o, ok_o, irq_o}, 0);
    rst = 0;
    idle(); idle();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule